// File: doc/BRIEF.md
# Digital Audio Line Presence Detector

This block watches a raw S/PDIF biphase-mark line and decides whether a live audio stream carrying non-silent program is present. An amplifier uses the result to mute itself or drop into standby when the source is absent, broken or quiet. The line is resynchronised to the system clock and sampled on a divided enable at about six samples per bit cell. The block measures the time between transitions, frames subframes on their preambles and grades each subframe.

Two tests run side by side. A repeating window counts good subframes and judges the stream valid only if enough arrived. A run counter watches the audio word of left-channel subframes and declares silence once the same value repeats often enough. The mute flag is raised whenever either test fails. The active-low mute and standby pins follow its inverse.

Top module: `audio_presence_det`

## Requirements
- R1: While reset is low, and from reset until the first validity window has ended, mute_o is 1, mute_n_o is 0 and stby_n_o is 0, whatever the line carries.
- R2: mute_n_o and stby_n_o are always the logical inverse of mute_o.
- R3: The line passes through a two-flop synchronizer and is sampled once every DIV clocks. A gap between transitions of 2 to 4 samples is a half cell, 5 to 7 is a full cell and 8 to 10 is a preamble-length pulse. Any other gap abandons the current subframe. A half cell that is one sample short or long is still decoded.
- R4: A subframe starts with one of three preamble pulse patterns, measured in half cells: 3,1,1,3 (left channel, block start), 3,3,1,1 (left channel) or 3,2,1,2 (right channel). After it come 28 data slots. A slot holding one full-cell pulse is 0, and a slot holding two half-cell pulses is 1. The slots are taken LSB first: 24 audio bits, then the validity flag, a user bit, a channel-status bit and the parity bit.
- R5: A subframe counts as good only if its 28 data slots hold an even number of ones and its validity flag is 0.
- R6: Each window lasts WIN_TICKS sample enables. At its end, the stream is judged valid only if at least VALID_MIN good subframes ended inside it. The count then restarts.
- R7: Each good left subframe whose audio word equals that of the previous good left subframe adds one to a run count. A different word clears the run count. The stream is silent while the run count is at least SILENT_RUN. The reference word is zero after reset.
- R8: Right-channel subframes neither add to nor clear the run count.
- R9: mute_o is 1 exactly when the stream was last judged not valid, or the stream is silent.
- R10: When the line stops toggling, mute_o is 1 by the end of the next full window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spdif_i | input | 1 | Raw biphase-mark audio line, asynchronous to clk |
| mute_o | output | 1 | 1 when the stream is absent, invalid or silent |
| mute_n_o | output | 1 | Active-low mute, inverse of mute_o |
| stby_n_o | output | 1 | Active-low standby, inverse of mute_o |

## Verification
The hardest condition to reach from the pins is a window holding an exact number of good subframes. Window phase is invisible from outside. The bench sets the window to exactly ten subframe durations and repeats a ten-subframe pattern with k good frames and the rest spoiled, either through the validity flag or through parity. Every window then holds exactly k good subframes at any phase, so sweeping k across the threshold gives exact expectations. Silence is reached the same way. Runs of repeated left words, with fresh right words between them, are swept in length around SILENT_RUN.

// File: rtl/apd_pkg.sv
package apd_pkg;

  localparam int AUDIO_W = 24;
  localparam int SLOT_N  = 28;
  localparam int VBIT    = 24;
  localparam int IV_W    = 4;

  typedef enum logic [1:0] {IV_HALF, IV_FULL, IV_PRE, IV_BAD} iv_e;
  typedef enum logic [1:0] {DS_HUNT, DS_PRE, DS_DATA} ds_e;

  // Gap length in sample enables -> pulse class (+-1 sample tolerance)
  function automatic iv_e iv_classify(input logic [IV_W-1:0] n);
    if (n >= 4'd2 && n <= 4'd4)       return IV_HALF;
    else if (n >= 4'd5 && n <= 4'd7)  return IV_FULL;
    else if (n >= 4'd8 && n <= 4'd10) return IV_PRE;
    else                              return IV_BAD;
  endfunction

  function automatic logic [3:0] iv_halves(input iv_e c);
    case (c)
      IV_HALF: return 4'd1;
      IV_FULL: return 4'd2;
      IV_PRE:  return 4'd3;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/apd_front.sv
module apd_front
  import apd_pkg::*;
#(
  parameter int DIV = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic tick_o,
  output logic iv_stb_o,
  output iv_e  iv_cls_o
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0]   DIV_LAST = DW'(DIV - 1);
  localparam logic [IV_W-1:0] RUN_MAX  = '1;

  logic [1:0]      sync_q;
  logic            lvl_q, lvl_d;
  logic [DW-1:0]   div_q, div_d;
  logic [IV_W-1:0] run_q, run_d;
  logic            stb_q, stb_d;
  iv_e             cls_q, cls_d;
  logic            tick;

  always_comb begin
    tick  = (div_q == DIV_LAST);
    div_d = tick ? '0 : div_q + 1'b1;
    lvl_d = lvl_q;
    run_d = run_q;
    stb_d = 1'b0;
    cls_d = cls_q;
    if (tick) begin
      lvl_d = sync_q[1];
      if (sync_q[1] != lvl_q) begin
        stb_d = 1'b1;
        cls_d = iv_classify(run_q);
        run_d = IV_W'(1);
      end else if (run_q != RUN_MAX) begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      div_q  <= '0;
      run_q  <= '0;
      stb_q  <= 1'b0;
      cls_q  <= IV_BAD;
    end else begin
      sync_q <= {sync_q[0], line_i};
      lvl_q  <= lvl_d;
      div_q  <= div_d;
      run_q  <= run_d;
      stb_q  <= stb_d;
      cls_q  <= cls_d;
    end
  end

  assign tick_o   = tick;
  assign iv_stb_o = stb_q;
  assign iv_cls_o = cls_q;

endmodule

// File: rtl/apd_bmc.sv
module apd_bmc
  import apd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               iv_stb_i,
  input  iv_e                iv_cls_i,
  output logic               sf_stb_o,
  output logic               sf_ok_o,
  output logic               sf_left_o,
  output logic [AUDIO_W-1:0] sf_audio_o
);

  ds_e               st_q, st_d;
  logic [3:0]        halves_q, halves_d;
  logic              second_q, second_d;
  logic              left_q, left_d;
  logic [4:0]        nbit_q, nbit_d;
  logic              part_q, part_d;
  logic [SLOT_N-1:0] sr_q, sr_d, sr_shift;
  logic              stb_q, stb_d, ok_q, ok_d, sl_q, sl_d;
  logic [AUDIO_W-1:0] au_q, au_d;
  logic [3:0]        sum;
  logic              bit_ev, bit_val;

  always_comb begin
    st_d     = st_q;
    halves_d = halves_q;
    second_d = second_q;
    left_d   = left_q;
    nbit_d   = nbit_q;
    part_d   = part_q;
    sr_d     = sr_q;
    stb_d    = 1'b0;
    ok_d     = ok_q;
    sl_d     = sl_q;
    au_d     = au_q;
    bit_ev   = 1'b0;
    bit_val  = 1'b0;
    sum      = halves_q + iv_halves(iv_cls_i);
    if (iv_stb_i) begin
      if (iv_cls_i == IV_BAD) begin
        st_d = DS_HUNT;
      end else begin
        case (st_q)
          DS_HUNT: if (iv_cls_i == IV_PRE) begin
            st_d     = DS_PRE;
            halves_d = 4'd3;
            second_d = 1'b0;
          end
          DS_PRE: begin
            if (!second_q) begin
              second_d = 1'b1;
              left_d   = (iv_cls_i != IV_FULL);
            end
            halves_d = sum;
            if (sum == 4'd8) begin
              st_d   = DS_DATA;
              nbit_d = '0;
              part_d = 1'b0;
            end else if (sum > 4'd8) begin
              st_d = DS_HUNT;
            end
          end
          DS_DATA: begin
            if (iv_cls_i == IV_PRE) begin
              st_d     = DS_PRE;
              halves_d = 4'd3;
              second_d = 1'b0;
            end else if (iv_cls_i == IV_FULL) begin
              if (part_q) st_d = DS_HUNT;
              else        bit_ev = 1'b1;
            end else if (part_q) begin
              bit_ev  = 1'b1;
              bit_val = 1'b1;
              part_d  = 1'b0;
            end else begin
              part_d = 1'b1;
            end
          end
          default: st_d = DS_HUNT;
        endcase
      end
    end
    sr_shift = {bit_val, sr_q[SLOT_N-1:1]};
    if (bit_ev) begin
      sr_d   = sr_shift;
      nbit_d = nbit_q + 1'b1;
      if (nbit_q == 5'(SLOT_N - 1)) begin
        st_d  = DS_HUNT;
        stb_d = 1'b1;
        ok_d  = ~(^sr_shift) & ~sr_shift[VBIT];
        sl_d  = left_q;
        au_d  = sr_shift[AUDIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= DS_HUNT;
      halves_q <= '0;
      second_q <= 1'b0;
      left_q   <= 1'b0;
      nbit_q   <= '0;
      part_q   <= 1'b0;
      sr_q     <= '0;
      stb_q    <= 1'b0;
      ok_q     <= 1'b0;
      sl_q     <= 1'b0;
      au_q     <= '0;
    end else begin
      st_q     <= st_d;
      halves_q <= halves_d;
      second_q <= second_d;
      left_q   <= left_d;
      nbit_q   <= nbit_d;
      part_q   <= part_d;
      sr_q     <= sr_d;
      stb_q    <= stb_d;
      ok_q     <= ok_d;
      sl_q     <= sl_d;
      au_q     <= au_d;
    end
  end

  assign sf_stb_o   = stb_q;
  assign sf_ok_o    = ok_q;
  assign sf_left_o  = sl_q;
  assign sf_audio_o = au_q;

endmodule

// File: rtl/apd_judge.sv
module apd_judge
  import apd_pkg::*;
#(
  parameter int WIN_TICKS  = 40000000,
  parameter int VALID_MIN  = 40000,
  parameter int SILENT_RUN = 44100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               sf_stb_i,
  input  logic               sf_ok_i,
  input  logic               sf_left_i,
  input  logic [AUDIO_W-1:0] sf_audio_i,
  output logic               win_end_o,
  output logic               silent_o,
  output logic               mute_o
);

  localparam int WW = $clog2(WIN_TICKS);
  localparam int CW = $clog2(VALID_MIN + 1);
  localparam int RW = $clog2(SILENT_RUN + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_TICKS - 1);
  localparam logic [CW-1:0] VMIN     = CW'(VALID_MIN);
  localparam logic [RW-1:0] RMIN     = RW'(SILENT_RUN);

  logic [WW-1:0]      win_q, win_d;
  logic [CW-1:0]      cnt_q, cnt_d, cnt_inc;
  logic               ok_q, ok_d;
  logic [RW-1:0]      run_q, run_d;
  logic [AUDIO_W-1:0] ref_q, ref_d;
  logic               win_end, good;

  always_comb begin
    win_end = tick_i && (win_q == WIN_LAST);
    win_d   = win_q;
    if (tick_i) win_d = win_end ? '0 : win_q + 1'b1;
    good    = sf_stb_i & sf_ok_i;
    cnt_inc = (good && cnt_q != VMIN) ? cnt_q + 1'b1 : cnt_q;
    cnt_d   = win_end ? '0 : cnt_inc;
    ok_d    = win_end ? (cnt_inc == VMIN) : ok_q;
    run_d   = run_q;
    ref_d   = ref_q;
    if (good && sf_left_i) begin
      ref_d = sf_audio_i;
      if (sf_audio_i == ref_q) begin
        if (run_q != RMIN) run_d = run_q + 1'b1;
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      ok_q  <= 1'b0;
      run_q <= '0;
      ref_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
      run_q <= run_d;
      ref_q <= ref_d;
    end
  end

  assign win_end_o = win_end;
  assign silent_o  = (run_q == RMIN);
  assign mute_o    = ~ok_q | silent_o;

endmodule

// File: rtl/audio_presence_det.sv
module audio_presence_det
  import apd_pkg::*;
#(
  parameter int DIV        = 5,
  parameter int WIN_TICKS  = 40000000,
  parameter int VALID_MIN  = 40000,
  parameter int SILENT_RUN = 44100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spdif_i,
  output logic mute_o,
  output logic mute_n_o,
  output logic stby_n_o
);

  logic [1:0]         rs_q;
  logic               rst_q_n;
  logic               tick, iv_stb;
  iv_e                iv_cls;
  logic               sf_stb, sf_ok, sf_left;
  logic [AUDIO_W-1:0] sf_audio;
  logic               win_end, silent, mute;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  apd_front #(.DIV(DIV)) u_front (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .line_i   (spdif_i),
    .tick_o   (tick),
    .iv_stb_o (iv_stb),
    .iv_cls_o (iv_cls)
  );

  apd_bmc u_bmc (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .iv_stb_i   (iv_stb),
    .iv_cls_i   (iv_cls),
    .sf_stb_o   (sf_stb),
    .sf_ok_o    (sf_ok),
    .sf_left_o  (sf_left),
    .sf_audio_o (sf_audio)
  );

  apd_judge #(
    .WIN_TICKS  (WIN_TICKS),
    .VALID_MIN  (VALID_MIN),
    .SILENT_RUN (SILENT_RUN)
  ) u_judge (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .tick_i     (tick),
    .sf_stb_i   (sf_stb),
    .sf_ok_i    (sf_ok),
    .sf_left_i  (sf_left),
    .sf_audio_i (sf_audio),
    .win_end_o  (win_end),
    .silent_o   (silent),
    .mute_o     (mute)
  );

  assign mute_o   = mute;
  assign mute_n_o = ~mute;
  assign stby_n_o = ~mute;

endmodule

// File: rtl/apd_chk.sv
module apd_chk
  import apd_pkg::*;
#(
  parameter int DIV       = 5,
  parameter int WIN_TICKS = 40000000
) (
  input logic               clk,
  input logic               rst_q_n,
  input logic               tick,
  input logic               sf_stb,
  input logic               sf_ok,
  input logic               sf_left,
  input logic [AUDIO_W-1:0] sf_audio,
  input logic               win_end,
  input logic               silent,
  input logic               mute
);

  localparam logic [31:0] LIM = 32'(DIV * WIN_TICKS - DIV);

  logic [31:0]        cyc_q;
  logic [AUDIO_W-1:0] ref_ck;
  logic               good_left;

  assign good_left = sf_stb && sf_ok && sf_left;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cyc_q  <= '0;
      ref_ck <= '0;
    end else begin
      if (cyc_q != LIM) cyc_q <= cyc_q + 1'b1;
      if (good_left) ref_ck <= sf_audio;
    end
  end

  // R1
  hold_until_window_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cyc_q < LIM) |-> mute);

  // R9
  mute_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(mute) |-> $past(win_end || sf_stb));

  // R3
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    sf_stb |-> $past(tick, 2));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    sf_stb |=> !sf_stb);

  // R7
  silence_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (good_left && sf_audio != ref_ck) |=> !silent);

endmodule

bind audio_presence_det apd_chk #(.DIV(DIV), .WIN_TICKS(WIN_TICKS)) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .tick     (tick),
  .sf_stb   (sf_stb),
  .sf_ok    (sf_ok),
  .sf_left  (sf_left),
  .sf_audio (sf_audio),
  .win_end  (win_end),
  .silent   (silent),
  .mute     (mute)
);

// File: tb/sim_audio_presence_det.sv
module sim_audio_presence_det;

  localparam int DIV = 2;
  localparam int WIN = 1920;
  localparam int VMIN = 6;
  localparam int SRUN = 3;
  localparam int PB = 0, PM = 1, PW = 2;

  logic clk, rst_n, line;
  logic mute, mute_n, stby_n;
  int   errors, checks, hidx, seq;
  bit   jit;
  logic p_mute, p_mn, p_sn;

  audio_presence_det #(.DIV(DIV), .WIN_TICKS(WIN), .VALID_MIN(VMIN), .SILENT_RUN(SRUN)) u0 (
    .clk(clk), .rst_n(rst_n), .spdif_i(line),
    .mute_o(mute), .mute_n_o(mute_n), .stby_n_o(stby_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic emit(int h);
    line = ~line;
    for (int i = 0; i < h; i++) begin
      int d;
      d = jit ? ((hidx % 2 == 0) ? 7 : 5) : 3 * DIV;
      repeat (d) @(negedge clk);
      hidx++;
    end
  endtask

  task automatic send(int pre, logic [23:0] au, bit v, bit badp);
    logic [27:0] d;
    case (pre)
      PB:      begin emit(3); emit(1); emit(1); emit(3); end
      PM:      begin emit(3); emit(3); emit(1); emit(1); end
      default: begin emit(3); emit(2); emit(1); emit(2); end
    endcase
    p_mute = mute; p_mn = mute_n; p_sn = stby_n;
    d = {(^{v, au}) ^ badp, 1'b0, 1'b0, v, au};
    for (int i = 0; i < 28; i++) begin
      if (d[i]) begin emit(1); emit(1); end
      else emit(2);
    end
  endtask

  function automatic logic [23:0] fresh();
    seq++;
    return 24'(seq * 7919 + 1);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    errors = 0; checks = 0; hidx = 0; seq = 0; jit = 0;
    rst_n = 1'b0; line = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1", "mute in reset", int'(mute), 1);
    chk("R2", "mute_n in reset", int'(mute_n), 0);
    chk("R2", "stby_n in reset", int'(stby_n), 0);
    rst_n = 1'b1;

    // R1: good stream, still inside first window
    for (int i = 0; i < 5; i++) send(i == 0 ? PB : (i % 2 ? PW : PM), fresh(), 0, 0);
    chk("R1", "mute before first window end", int'(p_mute), 1);
    for (int i = 0; i < 30; i++) send(i % 2 ? PW : PM, fresh(), 0, 0);
    chk("R6", "mute with good stream", int'(p_mute), 0);
    chk("R2", "mute_n with good stream", int'(p_mn), 1);
    chk("R2", "stby_n with good stream", int'(p_sn), 1);

    // R10: line stops
    repeat (8000) @(negedge clk);
    chk("R10", "mute after stream loss", int'(mute), 1);
    chk("R2", "stby_n after stream loss", int'(stby_n), 0);

    // R5 R6: exact count of good subframes per window
    for (int k = 4; k <= 7; k++) begin
      for (int f = 0; f < 30; f++) begin
        bit good;
        good = (f % 10) < k;
        send(f % 2 ? PW : PM, fresh(), !good && (k % 2 == 1), !good && (k % 2 == 0));
      end
      chk(k % 2 ? "R5 R6 validity flag" : "R5 R6 parity", "mute vs good count",
          int'(p_mute), (k < VMIN) ? 1 : 0);
    end
    for (int i = 0; i < 20; i++) send(i % 2 ? PW : PM, fresh(), 0, 0);
    chk("R6", "mute restored", int'(p_mute), 0);

    // R7 R8 R9: runs of repeated left words, fresh right words between
    for (int m = 0; m <= 4; m++) begin
      logic [23:0] x;
      x = fresh();
      send(PB, x, 0, 0);
      send(PW, fresh(), 0, 0);
      for (int r = 0; r < m; r++) begin
        send(PM, x, 0, 0);
        send(PW, fresh(), 0, 0);
      end
      send(PM, fresh(), 0, 0);
      chk("R7 R8 R9", "mute after repeated left words", int'(p_mute), (m >= SRUN) ? 1 : 0);
      send(PW, fresh(), 0, 0);
      chk("R7", "mute after differing left word", int'(p_mute), 0);
    end

    // R8: constant right words, changing left words
    for (int i = 0; i < 12; i++) send(i % 2 ? PW : PM, i % 2 ? 24'h5A5A5A : fresh(), 0, 0);
    chk("R8", "mute with constant right words", int'(p_mute), 0);

    // R3: jittered half cells
    repeat (8000) @(negedge clk);
    chk("R10", "mute after second loss", int'(mute), 1);
    jit = 1;
    for (int i = 0; i < 30; i++) send(i % 2 ? PW : PM, fresh(), 0, 0);
    chk("R3", "mute with jittered cells", int'(p_mute), 0);
    chk("R2", "mute_n with jittered cells", int'(p_mn), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule